// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Eight-Word Queue

This block sits between a 16-bit host bus and an ARINC 429 line driver. The host builds each 31-bit word with two strobed writes: the first-half write, then the second-half write. The finished word goes into an eight-entry queue. When transmission is enabled, a serializer takes words from the head of the queue. It appends a parity bit as bit 32 and sends each word bit 1 first on two return-to-zero lines. One line pulses for a one and the other pulses for a zero, and both lines rest low during nulls and word gaps.

Bit timing comes from the master clock divided by 10 (fast rate) or by 80 (slow rate). The block brings the chosen data clock out on a pin. A ready flag tells the host when the queue has drained and the last word has left the line.

The serializer is a five-state machine:
- IDLE waits for the enable with a non-empty queue. It pops the head word and moves to SYNC.
- SYNC lasts one half bit and then moves to MARK.
- MARK drives the bit for a half bit and then moves to SPACE.
- SPACE holds a null for a half bit. From SPACE the machine returns to MARK for the next bit, or goes to GAP after bit 32.
- GAP holds a null for eight half bits. At its end the machine either pops the next word straight into MARK, or returns to IDLE when the queue is empty or the enable is low.

Top module: `a429_tx_queue`

## Requirements
- R1: Field placement:
  - First-half write: bus bits 7..0 carry ARINC bits 1..8, with bus bit 7 holding bit 1. Bus bits 15..11 carry ARINC bits 9..13, with bus bit 15 holding bit 9. Bus bit 9 carries ARINC bit 30 and bus bit 10 carries ARINC bit 31. Bus bit 8 is unused.
  - Second-half write: bus bits 15..0 carry ARINC bits 29..14.
  - ARINC bit 1 is sent first and bit 32 last.
- R2: A second-half strobe queues a word only if a first-half strobe has come since the last completed pair. A lone second-half strobe changes nothing.
- R3: The queue holds 8 words. A second-half strobe that arrives while the queue is full is ignored, and the first 8 words are sent unchanged.
- R4: `tx_ready` is high after reset. It is low in the cycle after a word is queued. It returns high once the queue is empty and the half bit after the last word's bit 32 has begun.
- R5: With the queue non-empty, the first mark of bit 1 begins no more than 2.5 data-clock periods after `tx_enable` goes high.
- R6: Each bit lasts one data-clock period (DIV clocks). For the first DIV/2 clocks, `line_one` is high for a 1 or `line_zero` is high for a 0; for the second DIV/2 clocks both lines are low. The two lines are never high together.
- R7: When words are sent back to back, both lines stay low for 9·DIV/2 clocks between the mark of bit 32 and the mark of the next bit 1. That is the null half of bit 32 plus a four-bit gap. The lines are low whenever `tx_ready` is high.
- R8: Bit 32 makes the count of ones over all 32 bits odd when `cfg_even_parity` is 0, and even when it is 1.
- R9: DIV is 10 when `cfg_low_speed` is 0 and 80 when it is 1. `data_clk` has period DIV while a word is in flight, and it rests low when the serializer is idle.
- R10: Lowering `tx_enable` lets the word in flight finish and keeps the remaining words queued. Raising it again resumes with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| host_bus | input | 16 | Host data for either half-word write |
| load_first | input | 1 | One-cycle strobe that captures the first half |
| load_second | input | 1 | One-cycle strobe that captures the second half and queues the word |
| cfg_even_parity | input | 1 | 0 gives odd overall parity, 1 gives even |
| cfg_low_speed | input | 1 | 0 divides by 10, 1 divides by 80 |
| tx_enable | input | 1 | Allows words to leave the queue |
| tx_ready | output | 1 | High when the queue is empty and no word is on the line |
| line_one | output | 1 | Return-to-zero pulse for a 1 bit |
| line_zero | output | 1 | Return-to-zero pulse for a 0 bit |
| data_clk | output | 1 | Selected data clock, low while idle |

## Verification
The bench decodes every pulse on the two lines back into 32-bit words and compares each one with a word built independently from the host writes, so any misplaced field or wrong parity shows up as a bit mismatch. It sends:
- single words under both parity settings, which separates the odd and even rules;
- back-to-back pairs, which measure the null run between words and so tell a correct gap apart from an extra or missing half bit;
- a load of nine words into a stopped queue, which shows whether the ninth load is refused;
- a lone second-half strobe, which shows whether the half-word ordering is enforced;
- a mid-queue drop of the enable, which shows that exactly one word completes.

A slow-rate run checks pulse width and data-clock period, which tells the two dividers apart.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SYNC,
        S_MARK,
        S_SPACE,
        S_GAP
    } ser_state_t;

    localparam int ARINC_DATA_BITS = 31;
    localparam int HOST_W          = 16;
endpackage

// File: rtl/a429_loader.sv
module a429_loader #(
    parameter int DATA_W = 31,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus,
    input  logic              load_first,
    input  logic              load_second,
    input  logic              full,
    output logic              push,
    output logic              pending,
    output logic [DATA_W-1:0] word
);
    logic [BUS_W-1:0] first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            pending <= 1'b0;
        end else if (load_first) begin
            first_q <= bus;
            pending <= 1'b1;
        end else if (load_second) begin
            pending <= 1'b0;
        end
    end

    assign push = load_second && !load_first && pending && !full;

    // word[k] holds ARINC bit k+1
    always_comb begin
        word = '0;
        for (int k = 0; k < 8; k++)   word[k] = first_q[7-k];
        for (int k = 8; k < 13; k++)  word[k] = first_q[23-k];
        for (int k = 13; k < 29; k++) word[k] = bus[k-13];
        word[29] = first_q[9];
        word[30] = first_q[10];
    end
endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
    parameter int W     = 31,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wr_data,
    input  logic                       pop,
    output logic [W-1:0]               rd_data,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end
endmodule

// File: rtl/a429_rate_gen.sv
module a429_rate_gen #(
    parameter int HS_DIV = 10,
    parameter int LS_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    input  logic hold,
    output logic half_tick,
    output logic data_clk
);
    localparam int HS_HALF = HS_DIV / 2;
    localparam int LS_HALF = LS_DIV / 2;
    localparam int CW      = $clog2(LS_HALF + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit     = slow ? CW'(LS_HALF - 1) : CW'(HS_HALF - 1);
    assign half_tick = !hold && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            data_clk <= 1'b0;
        end else if (hold) begin
            cnt      <= '0;
            data_clk <= 1'b0;
        end else if (half_tick) begin
            cnt      <= '0;
            data_clk <= ~data_clk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/a429_serializer.sv
module a429_serializer
    import a429_tx_pkg::*;
#(
    parameter int W           = 31,
    parameter int GAP_HALVES  = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         even_par,
    input  logic         half_tick,
    input  logic         empty,
    input  logic [W-1:0] head,
    output logic         pop,
    output logic         hold,
    output logic         at_rest,
    output logic         line_one,
    output logic         line_zero
);
    localparam int BW = $clog2(W + 1);
    localparam int GW = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

    ser_state_t    state, next;
    logic [W:0]    shreg;
    logic [BW-1:0] bitcnt;
    logic [GW-1:0] gapcnt;
    logic          start, last_bit, gap_done, par_bit;

    assign start    = enable && !empty;
    assign last_bit = (bitcnt == BW'(W));
    assign gap_done = (gapcnt == GW'(GAP_HALVES - 1));
    assign par_bit  = even_par ? (^head) : ~(^head);

    always_comb begin
        next = state;
        pop  = 1'b0;
        unique case (state)
            S_IDLE:  if (start) begin
                         next = S_SYNC;
                         pop  = 1'b1;
                     end
            S_SYNC:  if (half_tick) next = S_MARK;
            S_MARK:  if (half_tick) next = S_SPACE;
            S_SPACE: if (half_tick) next = last_bit ? S_GAP : S_MARK;
            S_GAP:   if (half_tick && gap_done) begin
                         next = start ? S_MARK : S_IDLE;
                         pop  = start;
                     end
            default: next = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            gapcnt <= '0;
        end else if (pop) begin
            shreg  <= {par_bit, head};
            bitcnt <= '0;
        end else if (half_tick && state == S_SPACE) begin
            if (last_bit) begin
                gapcnt <= '0;
            end else begin
                shreg  <= shreg >> 1;
                bitcnt <= bitcnt + 1'b1;
            end
        end else if (half_tick && state == S_GAP) begin
            gapcnt <= gapcnt + 1'b1;
        end
    end

    always_comb begin
        hold      = (state == S_IDLE);
        at_rest   = (state == S_IDLE) || (state == S_GAP);
        line_one  = (state == S_MARK) && shreg[0];
        line_zero = (state == S_MARK) && !shreg[0];
    end
endmodule

// File: rtl/a429_tx_queue.sv
module a429_tx_queue
    import a429_tx_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HS_DIV   = 10,
    parameter int LS_DIV   = 80,
    parameter int GAP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] host_bus,
    input  logic        load_first,
    input  logic        load_second,
    input  logic        cfg_even_parity,
    input  logic        cfg_low_speed,
    input  logic        tx_enable,
    output logic        tx_ready,
    output logic        line_one,
    output logic        line_zero,
    output logic        data_clk
);
    localparam int W  = ARINC_DATA_BITS;
    localparam int CW = $clog2(DEPTH) + 1;

    logic [W-1:0]  new_word, head_word;
    logic          q_push, q_pop, q_full, q_empty, half_pending;
    logic [CW-1:0] q_count;
    logic          half_tick, ser_hold, ser_rest;

    a429_loader #(.DATA_W(W), .BUS_W(HOST_W)) u_load (
        .clk(clk), .rst_n(rst_n), .bus(host_bus),
        .load_first(load_first), .load_second(load_second),
        .full(q_full), .push(q_push), .pending(half_pending), .word(new_word)
    );

    a429_word_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(q_push), .wr_data(new_word),
        .pop(q_pop), .rd_data(head_word), .full(q_full), .empty(q_empty),
        .count(q_count)
    );

    a429_rate_gen #(.HS_DIV(HS_DIV), .LS_DIV(LS_DIV)) u_rate (
        .clk(clk), .rst_n(rst_n), .slow(cfg_low_speed), .hold(ser_hold),
        .half_tick(half_tick), .data_clk(data_clk)
    );

    a429_serializer #(.W(W), .GAP_HALVES(2 * GAP_BITS)) u_ser (
        .clk(clk), .rst_n(rst_n), .enable(tx_enable), .even_par(cfg_even_parity),
        .half_tick(half_tick), .empty(q_empty), .head(head_word),
        .pop(q_pop), .hold(ser_hold), .at_rest(ser_rest),
        .line_one(line_one), .line_zero(line_zero)
    );

    assign tx_ready = q_empty && ser_rest;
endmodule

// File: rtl/a429_tx_checker.sv
module a429_tx_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_second,
    input logic             tx_enable,
    input logic             tx_ready,
    input logic             line_one,
    input logic             line_zero,
    input logic             fifo_push,
    input logic             fifo_pop,
    input logic             fifo_full,
    input logic             half_pending,
    input logic [CNT_W-1:0] fifo_count
);
    AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_one, line_zero})); // R6

    AST_READY_DROPS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> !tx_ready); // R4

    AST_FULL_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && load_second && !fifo_pop) |=> fifo_count == $past(fifo_count)); // R3

    AST_LONE_SECOND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_second && !half_pending && !fifo_pop) |=> fifo_count == $past(fifo_count)); // R2

    AST_REST_LINES_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !(line_one || line_zero)); // R7

    AST_NO_POP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> !fifo_pop); // R10
endmodule

bind a429_tx_queue a429_tx_checker #(.CNT_W($clog2(DEPTH) + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_second(load_second), .tx_enable(tx_enable),
    .tx_ready(tx_ready), .line_one(line_one), .line_zero(line_zero),
    .fifo_push(q_push), .fifo_pop(q_pop), .fifo_full(q_full),
    .half_pending(half_pending), .fifo_count(q_count)
);

// File: tb/sim_a429_tx_queue.sv
module sim_a429_tx_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_bus = '0;
    logic        load_first = 1'b0, load_second = 1'b0;
    logic        cfg_even_parity = 1'b0, cfg_low_speed = 1'b0, tx_enable = 1'b0;
    logic        tx_ready, line_one, line_zero, data_clk;

    always #4 clk = ~clk;

    a429_tx_queue u0 (
        .clk(clk), .rst_n(rst_n), .host_bus(host_bus),
        .load_first(load_first), .load_second(load_second),
        .cfg_even_parity(cfg_even_parity), .cfg_low_speed(cfg_low_speed),
        .tx_enable(tx_enable), .tx_ready(tx_ready),
        .line_one(line_one), .line_zero(line_zero), .data_clk(data_clk)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // line decoder
    logic [31:0] rx_q [64];
    int          gap_of [64];
    int          rx_wr = 0, nbits = 0, mark_len = 0, null_len = 0;
    int          width_bad = 0, both_bad = 0, exp_half = 5;
    logic [31:0] rx_sh = '0;
    logic        prev_mark = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (line_one && line_zero) both_bad++;
            if (line_one || line_zero) begin
                if (!prev_mark) begin
                    rx_sh[nbits] = line_one;
                    if (nbits == 0) gap_of[rx_wr % 64] = null_len;
                    nbits++;
                    null_len = 0;
                    if (nbits == 32) begin
                        rx_q[rx_wr % 64] = rx_sh;
                        rx_wr++;
                        nbits = 0;
                    end
                end
                mark_len++;
            end else begin
                if (prev_mark) begin
                    if (mark_len != exp_half) width_bad++;
                    mark_len = 0;
                end
                null_len++;
            end
            prev_mark = line_one || line_zero;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_word(input logic [15:0] lo, input logic [15:0] hi,
                                             input logic even);
        logic [31:0] r = '0;
        for (int b = 1; b <= 8; b++)   r[b-1] = lo[8-b];
        for (int b = 9; b <= 13; b++)  r[b-1] = lo[24-b];
        for (int b = 14; b <= 29; b++) r[b-1] = hi[b-14];
        r[29] = lo[9];
        r[30] = lo[10];
        r[31] = even ? (^r[30:0]) : ~(^r[30:0]);
        return r;
    endfunction

    task automatic load(input logic [15:0] lo, input logic [15:0] hi);
        @(negedge clk); host_bus = lo; load_first = 1'b1;
        @(negedge clk); load_first = 1'b0; host_bus = hi; load_second = 1'b1;
        @(negedge clk); load_second = 1'b0;
    endtask

    task automatic wait_words(input int n, input int limit);
        for (int i = 0; i < limit && rx_wr < n; i++) @(negedge clk);
    endtask

    task automatic wait_ready(input int limit);
        for (int i = 0; i < limit && !tx_ready; i++) @(negedge clk);
    endtask

    task automatic first_mark_latency(output int lat);
        lat = 0;
        for (int i = 0; i < 400 && !(line_one || line_zero); i++) begin
            @(negedge clk); lat++;
        end
    endtask

    task automatic t_reset;
        check(tx_ready === 1'b1, "R4 reset ready", tx_ready, 1);
        check(line_one === 1'b0 && line_zero === 1'b0, "R7 reset lines null",
              {line_one, line_zero}, 0);
        check(data_clk === 1'b0, "R9 idle data_clk low", data_clk, 0);
    endtask

    task automatic t_single_odd;
        int base = rx_wr, lat, wb = width_bad;
        logic [31:0] e = ref_word(16'hA5C3, 16'h1F08, 1'b0);
        cfg_even_parity = 1'b0;
        load(16'hA5C3, 16'h1F08);
        check(tx_ready == 1'b0, "R4 ready low after load", tx_ready, 0);
        tx_enable = 1'b1;
        first_mark_latency(lat);
        check(lat >= 1 && lat <= 25, "R5 first bit latency", lat, 25);
        wait_words(base + 1, 2000);
        check(rx_q[base % 64] == e, "R1 word fields and order", rx_q[base % 64], e);
        check(($countones(rx_q[base % 64]) % 2) == 1, "R8 odd parity",
              $countones(rx_q[base % 64]), 1);
        check(width_bad == wb, "R6 mark width fast", width_bad - wb, 0);
        wait_ready(200);
        check(tx_ready == 1'b1, "R4 ready after drain", tx_ready, 1);
        tx_enable = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic t_even_pair;
        int base = rx_wr;
        logic [31:0] e0 = ref_word(16'h0401, 16'hFFFF, 1'b1);
        logic [31:0] e1 = ref_word(16'h7E80, 16'h0000, 1'b1);
        cfg_even_parity = 1'b1;
        load(16'h0401, 16'hFFFF);
        load(16'h7E80, 16'h0000);
        tx_enable = 1'b1;
        wait_words(base + 2, 3000);
        check(rx_q[base % 64] == e0, "R8 even parity word 0", rx_q[base % 64], e0);
        check(rx_q[(base + 1) % 64] == e1, "R8 even parity word 1", rx_q[(base + 1) % 64], e1);
        check(($countones(rx_q[base % 64]) % 2) == 0, "R8 even count",
              $countones(rx_q[base % 64]), 0);
        check(gap_of[(base + 1) % 64] == 45, "R7 word gap nulls",
              gap_of[(base + 1) % 64], 45);
        check(both_bad == 0, "R6 lines exclusive", both_bad, 0);
        wait_ready(300);
        tx_enable = 1'b0;
        cfg_even_parity = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic t_lone_second;
        int base = rx_wr;
        logic [31:0] e = ref_word(16'h3C3C, 16'hBEEF, 1'b0);
        @(negedge clk); host_bus = 16'h1234; load_second = 1'b1;
        @(negedge clk); load_second = 1'b0;
        check(tx_ready == 1'b1, "R2 lone second ignored", tx_ready, 1);
        load(16'h3C3C, 16'hBEEF);
        // a further lone second after a completed pair is also ignored
        @(negedge clk); host_bus = 16'h5555; load_second = 1'b1;
        @(negedge clk); load_second = 1'b0;
        tx_enable = 1'b1;
        wait_words(base + 1, 2000);
        wait_ready(300);
        repeat (600) @(negedge clk);
        check(rx_wr - base == 1, "R2 only paired word sent", rx_wr - base, 1);
        check(rx_q[base % 64] == e, "R2 paired word intact", rx_q[base % 64], e);
        tx_enable = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_full;
        int base = rx_wr, bad = 0;
        for (int i = 0; i < 9; i++) load(16'(16'h1111 * i + 16'h0101), 16'(16'hABCD ^ (i * 16'h0F11)));
        check(tx_ready == 1'b0, "R4 ready low with full queue", tx_ready, 0);
        tx_enable = 1'b1;
        wait_words(base + 8, 6000);
        repeat (800) @(negedge clk);
        check(rx_wr - base == 8, "R3 ninth load refused", rx_wr - base, 8);
        for (int i = 0; i < 8; i++)
            if (rx_q[(base + i) % 64] !=
                ref_word(16'(16'h1111 * i + 16'h0101), 16'(16'hABCD ^ (i * 16'h0F11)), 1'b0))
                bad++;
        check(bad == 0, "R3 eight queued words in order", bad, 0);
        check(tx_ready == 1'b1, "R4 ready after queue drains", tx_ready, 1);
        tx_enable = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_hold;
        int base = rx_wr, lat, bad = 0;
        load(16'h0F0F, 16'h1001);
        load(16'hF0F0, 16'h2002);
        load(16'h8181, 16'h4004);
        tx_enable = 1'b1;
        first_mark_latency(lat);
        tx_enable = 1'b0;
        repeat (1500) @(negedge clk);
        check(rx_wr - base == 1, "R10 current word finishes only", rx_wr - base, 1);
        check(tx_ready == 1'b0, "R10 remaining words held", tx_ready, 0);
        tx_enable = 1'b1;
        wait_words(base + 3, 3000);
        if (rx_q[base % 64] != ref_word(16'h0F0F, 16'h1001, 1'b0)) bad++;
        if (rx_q[(base + 1) % 64] != ref_word(16'hF0F0, 16'h2002, 1'b0)) bad++;
        if (rx_q[(base + 2) % 64] != ref_word(16'h8181, 16'h4004, 1'b0)) bad++;
        check(bad == 0, "R10 resume sends held words", bad, 0);
        wait_ready(300);
        tx_enable = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    task automatic t_low_speed;
        int base = rx_wr, lat, wb = width_bad, t0 = 0, per = 0;
        logic prev;
        logic [31:0] e = ref_word(16'h6A95, 16'hC003, 1'b0);
        cfg_low_speed = 1'b1;
        exp_half = 40;
        load(16'h6A95, 16'hC003);
        tx_enable = 1'b1;
        first_mark_latency(lat);
        check(lat >= 1 && lat <= 200, "R5 first bit latency slow", lat, 200);
        prev = data_clk;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (data_clk && !prev) begin
                if (t0 == 0) t0 = i + 1;
                else if (per == 0) per = i + 1 - t0;
            end
            prev = data_clk;
        end
        check(per == 80, "R9 slow data clock period", per, 80);
        wait_words(base + 1, 4000);
        check(rx_q[base % 64] == e, "R9 slow word content", rx_q[base % 64], e);
        check(width_bad == wb, "R6 mark width slow", width_bad - wb, 0);
        wait_ready(800);
        tx_enable = 1'b0;
        repeat (100) @(negedge clk);
        cfg_low_speed = 1'b0;
        exp_half = 5;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_odd();
        t_even_pair();
        t_lone_second();
        t_full();
        t_hold();
        t_low_speed();
        finish_run();
    end
endmodule